// File: doc/BRIEF.md
# Flash Sector Protection Guard

This block sits between a host and the command engine of a serial NOR flash controller. It keeps the block-protect setting of the flash, which is a 4-bit protection level and a bottom/top anchor bit. It decodes the memory-operation commands that the host writes into a small register file. It also screens every erase and every program request against the address range that the setting protects. Operations that are allowed are placed in a one-entry output slot and passed to the downstream flash engine on a valid/ready handshake. Operations that are refused never reach the engine and raise sticky interrupt flags instead.

Protection works in whole 64 KiB sectors. A non-zero level L protects 2^(L-1) sectors, capped at the full device. When the anchor bit is set, the region starts at sector 0. When it is clear, the region ends at the last sector. The device holds 2^(ADDR_W-16) sectors.

The host reaches the registers through a single-cycle write strobe with a word address, and through a combinational read port. Program requests arrive on their own valid/ready pair.

Top module: `flash_guard`

## Requirements
- R1: After reset, status, flags and mask all read 0, `irq` is 0 and `eng_valid` is 0.
- R2: A command word written to word address 1 with bits 7:0 = 3 loads the protection level from bits 11:8 and the anchor bit from bit 12. A level of 0 with an anchor of 0 removes all protection. Word address 0 reads the setting back as follows: level bits 2:0 at bits 4:2, the anchor at bit 5 and level bit 3 at bit 6.
- R3: Level 0 protects nothing. A level L > 0 protects 2^(L-1) sectors, capped at the whole device. With anchor 1 these are the lowest sectors; with anchor 0 they are the highest.
- R4: A command with bits 7:0 = 2 is a sector erase of the sector index found at bit 8 and up. If that sector is unprotected, then on the cycle after the write `eng_valid` rises with `eng_op` = 2 and `eng_addr` = index × 64 KiB.
- R5: A sector erase of a protected sector is not forwarded and sets flag bit 0.
- R6: A command with bits 7:0 = 1 is a bulk erase. It is forwarded with `eng_op` = 1 and `eng_addr` = 0 only when the level is 0. Otherwise it is refused and sets flag bit 0.
- R7: A program request accepted on `wr_valid`/`wr_ready` is forwarded with `eng_op` = 3 and its byte address when its sector is unprotected. When the sector is protected, the request is dropped and flag bit 1 is set.
- R8: `eng_valid`, `eng_op` and `eng_addr` hold steady until `eng_ready`. `wr_ready` is low while the slot is full, and also while an erase command is being written. A legal erase written while the slot is full is discarded.
- R9: The flags at word address 2 are sticky. Writing 1 to a bit clears it. A violation arriving in the same cycle as a clear leaves the flag set.
- R10: Word address 3 holds a 2-bit mask. `irq` is high exactly when some flag bit and its mask bit are both set.
- R11: Command words whose bits 7:0 are not 1, 2 or 3 change nothing and forward nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wr_valid | input | 1 | Program request valid |
| wr_addr | input | ADDR_W | Program request byte address |
| wr_ready | output | 1 | Program request accepted |
| eng_valid | output | 1 | Forwarded operation valid |
| eng_ready | input | 1 | Engine takes the operation |
| eng_op | output | 2 | 1 bulk erase, 2 sector erase, 3 program |
| eng_addr | output | ADDR_W | Operation byte address |
| irq | output | 1 | Interrupt request |

## Verification
Each register write, and each program request, takes effect at the clock edge that samples it. A forwarded operation therefore shows on the engine port from that edge onward. A flag, and `irq`, change at the same edge, and a changed protection setting first applies to commands sampled at the next edge. The bench drives on falling edges and reads registers just after them. A monitor samples the engine port slightly later and compares each handshake against the queue of operations the driver expected. Refused or ignored operations are checked through the flags, through the status register and through an empty queue.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int SECT_BITS = 16;

    localparam logic [1:0] RA_STATUS = 2'd0;
    localparam logic [1:0] RA_MEMOP  = 2'd1;
    localparam logic [1:0] RA_FLAGS  = 2'd2;
    localparam logic [1:0] RA_MASK   = 2'd3;

    localparam logic [7:0] OPC_BULK    = 8'd1;
    localparam logic [7:0] OPC_SECTOR  = 8'd2;
    localparam logic [7:0] OPC_PROTECT = 8'd3;

    typedef enum logic [1:0] {
        ENG_NONE    = 2'd0,
        ENG_BULK    = 2'd1,
        ENG_SECTOR  = 2'd2,
        ENG_PROGRAM = 2'd3
    } eng_op_e;

    typedef struct packed {
        logic       tb;
        logic [3:0] level;
    } prot_t;

    // True when sector index sect (of nbits significant bits) lies in the guarded range
    function automatic logic sect_locked(input logic [31:0] sect, input int nbits,
                                         input prot_t p);
        logic [31:0] s;
        int          sh;
        if (p.level == 4'd0) return 1'b0;
        sh = int'(p.level) - 1;
        if (sh >= nbits) return 1'b1;
        s = p.tb ? sect : (~sect & ((32'd1 << nbits) - 32'd1));
        return (s >> sh) == 32'd0;
    endfunction

endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
    import flash_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        prot_we,
    input  prot_t       prot_new,
    input  logic        set_erase_err,
    input  logic        set_write_err,
    output prot_t       prot,
    output logic [1:0]  flags,
    output logic [1:0]  mask,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    logic [1:0] clr;
    logic [1:0] set;

    assign clr = (reg_we && reg_addr == RA_FLAGS) ? reg_wdata[1:0] : 2'b00;
    assign set = {set_write_err, set_erase_err};

    always_ff @(posedge clk) begin
        if (rst) begin
            prot  <= '0;
            flags <= '0;
            mask  <= '0;
        end else begin
            if (prot_we) prot <= prot_new;
            flags <= (flags & ~clr) | set;
            if (reg_we && reg_addr == RA_MASK) mask <= reg_wdata[1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_STATUS: reg_rdata[6:2] = {prot.level[3], prot.tb, prot.level[2:0]};
            RA_FLAGS:  reg_rdata[1:0] = flags;
            RA_MASK:   reg_rdata[1:0] = mask;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(flags & mask);

endmodule

// File: rtl/flash_guard_check.sv
module flash_guard_check
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int NSECT_W = ADDR_W - SECT_BITS
) (
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  prot_t             prot,
    input  logic              slot_full,
    output logic              wr_ready,
    output logic              prot_we,
    output prot_t             prot_new,
    output logic              load,
    output eng_op_e           load_op,
    output logic [ADDR_W-1:0] load_addr,
    output logic              erase_err,
    output logic              write_err
);
    logic               memop_wr;
    logic [7:0]         opc;
    logic               is_bulk, is_sect;
    logic [NSECT_W-1:0] sect_idx;
    logic               sect_lock, wr_lock, any_prot;
    logic               erase_cmd, erase_ok, wr_take;

    assign memop_wr = reg_we && reg_addr == RA_MEMOP;
    assign opc      = reg_wdata[7:0];
    assign is_bulk  = opc == OPC_BULK;
    assign is_sect  = opc == OPC_SECTOR;
    assign sect_idx = reg_wdata[8 +: NSECT_W];
    assign any_prot = prot.level != 4'd0;

    assign sect_lock = sect_locked({{(32-NSECT_W){1'b0}}, sect_idx}, NSECT_W, prot);
    assign wr_lock   = sect_locked({{(32-NSECT_W){1'b0}}, wr_addr[ADDR_W-1:SECT_BITS]},
                                   NSECT_W, prot);

    assign erase_cmd = memop_wr && (is_bulk || is_sect);
    assign erase_err = memop_wr && ((is_bulk && any_prot) || (is_sect && sect_lock));
    assign erase_ok  = erase_cmd && !erase_err;

    assign wr_ready  = !slot_full && !erase_cmd;
    assign wr_take   = wr_valid && wr_ready;
    assign write_err = wr_take && wr_lock;

    assign load = (erase_ok && !slot_full) || (wr_take && !wr_lock);

    always_comb begin
        if (erase_ok) begin
            load_op   = is_bulk ? ENG_BULK : ENG_SECTOR;
            load_addr = is_bulk ? '0 : {sect_idx, {SECT_BITS{1'b0}}};
        end else begin
            load_op   = ENG_PROGRAM;
            load_addr = wr_addr;
        end
    end

    assign prot_we        = memop_wr && opc == OPC_PROTECT;
    assign prot_new.level = reg_wdata[11:8];
    assign prot_new.tb    = reg_wdata[12];

endmodule

// File: rtl/flash_guard_slot.sv
module flash_guard_slot
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  eng_op_e           load_op,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              eng_ready,
    output logic              eng_valid,
    output eng_op_e           eng_op,
    output logic [ADDR_W-1:0] eng_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            eng_valid <= 1'b0;
            eng_op    <= ENG_NONE;
            eng_addr  <= '0;
        end else if (load) begin
            eng_valid <= 1'b1;
            eng_op    <= load_op;
            eng_addr  <= load_addr;
        end else if (eng_valid && eng_ready) begin
            eng_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_ready,
    output logic              eng_valid,
    input  logic              eng_ready,
    output logic [1:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic              irq
);
    localparam int NSECT_W = ADDR_W - SECT_BITS;

    prot_t             prot_q, prot_new;
    logic              prot_we;
    logic [1:0]        flags_q, mask_q;
    logic              load, erase_err, write_err;
    eng_op_e           load_op, slot_op;
    logic [ADDR_W-1:0] load_addr;

    flash_guard_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .prot_we       (prot_we),
        .prot_new      (prot_new),
        .set_erase_err (erase_err),
        .set_write_err (write_err),
        .prot          (prot_q),
        .flags         (flags_q),
        .mask          (mask_q),
        .reg_rdata     (reg_rdata),
        .irq           (irq)
    );

    flash_guard_check #(.ADDR_W(ADDR_W), .NSECT_W(NSECT_W)) u_check (
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .prot      (prot_q),
        .slot_full (eng_valid),
        .wr_ready  (wr_ready),
        .prot_we   (prot_we),
        .prot_new  (prot_new),
        .load      (load),
        .load_op   (load_op),
        .load_addr (load_addr),
        .erase_err (erase_err),
        .write_err (write_err)
    );

    flash_guard_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_op   (load_op),
        .load_addr (load_addr),
        .eng_ready (eng_ready),
        .eng_valid (eng_valid),
        .eng_op    (slot_op),
        .eng_addr  (eng_addr)
    );

    assign eng_op = slot_op;

endmodule

// File: rtl/flash_guard_sva.sv
module flash_guard_sva
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              wr_ready,
    input logic              eng_valid,
    input logic              eng_ready,
    input logic [1:0]        eng_op,
    input logic [ADDR_W-1:0] eng_addr,
    input logic              irq,
    input prot_t             prot,
    input logic [1:0]        flags,
    input logic [1:0]        mask
);
    localparam int NSECT_W = ADDR_W - SECT_BITS;

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        eng_valid && !eng_ready |=> eng_valid && $stable(eng_op) && $stable(eng_addr)); // R8

    AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        eng_valid && !eng_ready |-> !wr_ready); // R8

    AST_BULK_ONLY_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_valid) && eng_op == 2'd1 |-> $past(prot.level) == 4'd0); // R6

    AST_PROGRAM_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_valid) && eng_op == 2'd3 |->
        !sect_locked({{(32-NSECT_W){1'b0}}, eng_addr[ADDR_W-1:SECT_BITS]}, NSECT_W,
                     $past(prot))); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags[0] && !(reg_we && reg_addr == RA_FLAGS && reg_wdata[0]) |=> flags[0]); // R9

    AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (rst)
        mask == 2'b00 |-> !irq); // R10

endmodule

bind flash_guard flash_guard_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wr_ready  (wr_ready),
    .eng_valid (eng_valid),
    .eng_ready (eng_ready),
    .eng_op    (eng_op),
    .eng_addr  (eng_addr),
    .irq       (irq),
    .prot      (prot_q),
    .flags     (flags_q),
    .mask      (mask_q)
);

// File: tb/test_flash_guard.sv
module test_flash_guard;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              wr_ready;
    logic              eng_valid;
    logic              eng_ready = 1'b1;
    logic [1:0]        eng_op;
    logic [ADDR_W-1:0] eng_addr;
    logic              irq;

    typedef struct {
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
    } exp_t;

    exp_t expq[$];
    int   n_tests = 0;
    int   n_fail  = 0;

    flash_guard #(.ADDR_W(ADDR_W)) i_flash_guard (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_ready(wr_ready), .eng_valid(eng_valid),
        .eng_ready(eng_ready), .eng_op(eng_op), .eng_addr(eng_addr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Monitor: compare every engine handshake against the expected queue
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && eng_valid && eng_ready) begin
                if (expq.size() == 0) begin
                    check("R8 unexpected engine op", {30'd0, eng_op}, 32'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check("R4/R6/R7 engine op", {30'd0, eng_op}, {30'd0, e.op});
                    check("R4/R6/R7 engine addr", {8'd0, eng_addr}, {8'd0, e.addr});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        reg_rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic push(input logic [1:0] op, input logic [ADDR_W-1:0] a);
        exp_t e;
        e.op = op; e.addr = a;
        expq.push_back(e);
    endtask

    task automatic erase_sector(input int idx, input bit ok);
        if (ok) push(2'd2, ADDR_W'(idx) << 16);
        reg_wr(2'd1, (32'(idx) << 8) | 32'd2);
    endtask

    task automatic bulk(input bit ok);
        if (ok) push(2'd1, '0);
        reg_wr(2'd1, 32'd1);
    endtask

    task automatic protect(input int level, input bit tb);
        reg_wr(2'd1, (32'(tb) << 12) | (32'(level) << 8) | 32'd3);
    endtask

    task automatic host_write(input logic [ADDR_W-1:0] a, input bit ok);
        if (ok) push(2'd3, a);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a;
        #1 check("R8 wr_ready when idle", {31'd0, wr_ready}, 32'd1);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drained(input string tag);
        idle(3);
        check(tag, expq.size(), 32'd0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        #1 check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 eng_valid", {31'd0, eng_valid}, 32'd0);
        expect_reg("R1 status", 2'd0, 32'd0);
        expect_reg("R1 flags", 2'd2, 32'd0);
        expect_reg("R1 mask", 2'd3, 32'd0);

        // R4 / R6 without protection
        erase_sector(5, 1);
        drained("R4 sector erase forwarded");
        bulk(1);
        drained("R6 bulk forwarded when unlocked");

        // R2 / R3 level 3, top anchored: sectors 252..255
        protect(3, 0);
        expect_reg("R2 status level3 top", 2'd0, 32'h0000_000C);
        erase_sector(251, 1);
        erase_sector(252, 0);
        drained("R3 below top range forwarded");
        expect_reg("R5 flag on locked erase", 2'd2, 32'd1);
        reg_wr(2'd2, 32'd1);
        expect_reg("R9 W1C clears flag", 2'd2, 32'd0);
        bulk(0);
        drained("R6 bulk refused");
        expect_reg("R6 flag on refused bulk", 2'd2, 32'd1);
        reg_wr(2'd2, 32'd1);

        // R7 program requests
        host_write(24'hFC0000, 0);
        expect_reg("R7 flag on locked write", 2'd2, 32'd2);
        host_write(24'hFBFFFF, 1);
        drained("R7 write outside forwarded");

        // R10 mask
        reg_wr(2'd3, 32'd1);
        #1 check("R10 irq masked off", {31'd0, irq}, 32'd0);
        reg_wr(2'd3, 32'd2);
        #1 check("R10 irq unmasked", {31'd0, irq}, 32'd1);
        expect_reg("R10 mask readback", 2'd3, 32'd2);

        // R9 set wins over clear
        reg_wr(2'd2, 32'd3);
        #1 check("R9 cleared irq low", {31'd0, irq}, 32'd0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd2;
        wr_valid = 1'b1; wr_addr = 24'hFC0000;
        @(negedge clk);
        reg_we = 1'b0; wr_valid = 1'b0;
        expect_reg("R9 set wins over clear", 2'd2, 32'd2);
        reg_wr(2'd2, 32'd3);

        // R2 / R3 level 9 bottom: capped at whole device
        protect(9, 1);
        expect_reg("R2 status level9 bottom", 2'd0, 32'h0000_0064);
        erase_sector(255, 0);
        expect_reg("R3 cap covers last sector", 2'd2, 32'd1);
        reg_wr(2'd2, 32'd3);

        // R3 level 2 bottom: sectors 0..1
        protect(2, 1);
        erase_sector(2, 1);
        erase_sector(1, 0);
        drained("R3 bottom boundary");
        expect_reg("R3 sector 1 locked", 2'd2, 32'd1);
        host_write(24'h01FFFF, 0);
        expect_reg("R7 last locked byte", 2'd2, 32'd3);
        host_write(24'h020000, 1);
        drained("R7 first free byte forwarded");
        reg_wr(2'd2, 32'd3);

        // R11 unknown opcodes
        protect(4, 0);
        reg_wr(2'd1, 32'h0000_0083);
        reg_wr(2'd1, 32'h0000_0704);
        reg_wr(2'd1, 32'h0000_0500);
        drained("R11 nothing forwarded");
        expect_reg("R11 status unchanged", 2'd0, 32'h0000_0010);
        expect_reg("R11 no flags", 2'd2, 32'd0);

        // R2 unprotect then bulk
        protect(0, 0);
        expect_reg("R2 unprotect", 2'd0, 32'd0);
        bulk(1);
        drained("R6 bulk after unprotect");

        // R8 backpressure
        @(negedge clk);
        eng_ready = 1'b0;
        host_write(24'h100000, 1);
        @(negedge clk);
        #1 check("R8 wr_ready low while full", {31'd0, wr_ready}, 32'd0);
        erase_sector(9, 0);
        idle(3);
        #1 check("R8 valid held", {31'd0, eng_valid}, 32'd1);
        check("R8 addr held", {8'd0, eng_addr}, 32'h0010_0000);
        @(negedge clk);
        eng_ready = 1'b1;
        drained("R8 only held op delivered");
        #1 check("R8 slot empty after take", {31'd0, eng_valid}, 32'd0);

        finish_run();
    end

endmodule